// File: doc/BRIEF.md
# Edge-Triggered Line Interrupt Capture

This block watches 24 digital I/O lines for signal edges and raises an interrupt for the host. Each line has its own direction select and its own enable. The direction select picks a rising edge or a falling edge, judged on the real pin level. When an enabled line shows an edge in its chosen direction, a sticky flag for that line is set. The flag stays set until software clears it.

The 24 flags form three byte-wide groups. The host reads them through its register decode and clears them by byte, with a data pattern in which a 0 clears a flag and a 1 leaves it alone. A three-bit summary marks which byte groups hold at least one set flag. The interrupt request is the OR of that summary.

Pins are asynchronous, so each one passes through a two-flop synchronizer before edge detection. Edges are not reported until the synchronizer holds real pin data after reset.

Top module: `edge_irq_capture`

## Requirements
- R1: Flag bit i of `id_o` belongs to line i (`pin_i[i]`). Byte group b is `id_o[8b+7:8b]` and covers lines 8b to 8b+7, with b from 0 to 2.
- R2: When `pol_i[i]`=1, a rising edge on line i sets flag i. When `pol_i[i]`=0, a falling edge sets it. The flag appears after the third rising clock edge that follows the pin change (two synchronizer stages plus the flag register).
- R3: A line whose `en_i` bit is 0 at the clock edge where its edge is detected does not set its flag.
- R4: A set flag stays set whatever the pins do, and clearing its enable bit does not clear it.
- R5: When `clr_we_i[b]`=1, each bit of `clr_data_i` that is 0 clears the matching flag of byte group b on the next clock edge. Each bit that is 1 leaves its flag unchanged. Groups whose strobe is 0 are untouched.
- R6: If a new edge for a line and a clear of that line's flag fall on the same clock edge, the flag ends up set.
- R7: `pend_o[b]` is 1 exactly when byte group b of `id_o` holds any set bit, in the same cycle.
- R8: `irq_o` is active high and is 1 exactly when any bit of `pend_o` is 1.
- R9: While `rst_n` is low, all flags are 0. No flag is set from pin levels present during reset: edges are only judged from the fourth clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 24 | True pin levels, asynchronous |
| pol_i | input | 24 | Per-line edge direction: 1 rising, 0 falling |
| en_i | input | 24 | Per-line capture enable |
| clr_we_i | input | 3 | Per-byte-group clear strobe |
| clr_data_i | input | 8 | Clear pattern: 0 clears, 1 keeps |
| id_o | output | 24 | Sticky edge flags |
| pend_o | output | 3 | Per-byte-group pending summary |
| irq_o | output | 1 | Interrupt request |

## Verification
Pins are first held high through reset and the warm-up cycles. This separates a true edge from a level left over from reset. Directed steps then pair a rise and a fall with each polarity setting, which separates rising capture from falling capture. They also toggle a disabled line, drop an enable after its flag is set, and clear one group with a mixed 0/1 pattern while a new edge lands on a line being cleared. Long random runs vary pins, polarities, enables and clears every cycle. These compare flags, summary and request with a cycle-accurate reference, which catches any error in delay, byte grouping or set/clear priority.

// File: rtl/edge_irq_capture.sv
module edge_irq_capture #(
  parameter int LINES  = 24,
  parameter int BYTE_W = 8,
  localparam int NB    = LINES / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  pin_i,
  input  logic [LINES-1:0]  pol_i,
  input  logic [LINES-1:0]  en_i,
  input  logic [NB-1:0]     clr_we_i,
  input  logic [BYTE_W-1:0] clr_data_i,
  output logic [LINES-1:0]  id_o,
  output logic [NB-1:0]     pend_o,
  output logic              irq_o
);

  logic [LINES-1:0] s1_q, s2_q, s3_q, id_q, hit, keep;
  logic [1:0]       warm_q;

  assign hit = (warm_q == 2'd3)
             ? (en_i & ((pol_i & s2_q & ~s3_q) | (~pol_i & ~s2_q & s3_q)))
             : '0;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign keep[b*BYTE_W +: BYTE_W] = clr_we_i[b] ? clr_data_i : '1;
    assign pend_o[b] = |id_q[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
      id_q   <= '0;
      warm_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
      id_q <= (id_q & keep) | hit;
    end
  end

  assign id_o  = id_q;
  assign irq_o = |pend_o;

  // R3
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((id_q & ~$past(id_q) & ~$past(en_i)) == '0));

  // R5
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (($past(id_q) & ~id_q & $past(keep)) == '0));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(hit) != '0));

  // R9
  warmup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q != 2'd3) |=> (id_q == '0));

endmodule

// File: tb/edge_irq_capture_test.sv
module edge_irq_capture_test;
  localparam int L = 24;
  localparam int W = 8;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [L-1:0] pin = '1, pol = '1, en = '1;
  logic [N-1:0] clr_we = '0;
  logic [W-1:0] clr_data = '1;
  logic [L-1:0] id;
  logic [N-1:0] pend;
  logic irq;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [L-1:0] m_d1, m_d2, m_d3, m_id;
  int m_warm;

  always #2 clk = ~clk;

  edge_irq_capture uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .pol_i(pol), .en_i(en),
    .clr_we_i(clr_we), .clr_data_i(clr_data),
    .id_o(id), .pend_o(pend), .irq_o(irq));

  function automatic logic [N-1:0] exp_pend(logic [L-1:0] f);
    logic [N-1:0] p;
    for (int b = 0; b < N; b++) p[b] = |f[b*W +: W];
    return p;
  endfunction

  function automatic logic [L-1:0] exp_hit();
    logic [L-1:0] r, f;
    if (m_warm < 3) return '0;
    r = m_d2 & ~m_d3;
    f = ~m_d2 & m_d3;
    return en & ((pol & r) | (~pol & f));
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, 64'(id), 64'(m_id));
    chk("R7", 64'(pend), 64'(exp_pend(m_id)));
    chk("R8", 64'(irq), 64'(|exp_pend(m_id)));
  endtask

  task automatic step(string tag);
    logic [L-1:0] keep;
    for (int b = 0; b < N; b++)
      keep[b*W +: W] = clr_we[b] ? clr_data : '1;
    m_id = (m_id & keep) | exp_hit();
    m_d3 = m_d2; m_d2 = m_d1; m_d1 = pin;
    if (m_warm < 3) m_warm++;
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
    clr_we = '0;
    clr_data = '1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_d1 = '0; m_d2 = '0; m_d3 = '0; m_id = '0; m_warm = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R9");
    rst_n = 1'b1;
    // R9: pins high from reset must not look like rising edges
    repeat (5) step("R9");
    // R2 rising on line 0 and falling on line 9
    pin = '1; pin[0] = 1'b0; pin[9] = 1'b1; pol[9] = 1'b0;
    repeat (4) step("R2");
    pin[0] = 1'b1;
    step("R2"); step("R2"); step("R2");
    chk("R1", 64'(id[0]), 64'd1);
    pin[9] = 1'b0;
    repeat (3) step("R2");
    chk("R1", 64'(id[9]), 64'd1);
    // R3 disabled line 20 toggles
    en[20] = 1'b0; pin[20] = 1'b0;
    repeat (3) step("R3");
    pin[20] = 1'b1;
    repeat (4) step("R3");
    chk("R3", 64'(id[20]), 64'd0);
    // R4 drop enable of line 0, flag remains
    en[0] = 1'b0;
    repeat (3) step("R4");
    chk("R4", 64'(id[0]), 64'd1);
    // R5 clear group 1 with mixed pattern, group 0 untouched
    clr_we = 3'b010; clr_data = 8'hFD;
    step("R5");
    chk("R5", 64'(id[9]), 64'd0);
    chk("R5", 64'(id[0]), 64'd1);
    // R6 edge on line 17 meets a clear of line 17
    pin[17] = 1'b0; repeat (4) step("R6");
    pin[17] = 1'b1; step("R6"); step("R6");
    clr_we = 3'b100; clr_data = 8'h00;
    step("R6");
    chk("R6", 64'(id[17]), 64'd1);
    clr_we = 3'b111; clr_data = 8'h00;
    step("R5");
    chk("R5", 64'(id), 64'd0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      pin = L'($urandom);
      if ($urandom_range(0, 15) == 0) pol = L'($urandom);
      if ($urandom_range(0, 15) == 0) en = L'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        clr_we = N'($urandom);
        clr_data = W'($urandom);
      end
      step("R2");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule